// File: doc/BRIEF.md
# Screen-Region Triangle Distributor

This block sits between geometry processing and a group of parallel rasterizers. It takes screen-space triangles, each given as three fixed-point vertices, over a valid/ready input. It then hands each triangle to every rasterizer that owns a piece of the screen the triangle might touch. Triangles that face away from the viewer are dropped. So are triangles with zero area. No rasterizer ever sees either kind.

For each surviving triangle the block computes a bounding box in whole pixels, widened so that it starts and ends on 2x2 quad boundaries. The screen is cut into 16x16-pixel tiles, and the tiles are dealt out to four rasterizers in a 2x2 interleave. Every rasterizer owning a tile inside the box receives the triangle together with its box. A single holding slot keeps the triangle until all of the chosen rasterizers have taken it, and the input is stalled for that whole time. A large triangle is therefore shared out among several rasterizers at once, and each rasterizer still receives triangles in the order they came in.

Top module: `tri_distrib`

## Requirements
- R1: After reset, `tri_ready_o` is 1 and `out_valid_o` is all zero.
- R2: Vertex coordinates are unsigned with 4 fractional bits. The signed area is A = (x1-x0)*(y2-y0) - (x2-x0)*(y1-y0), taken on the raw coordinates. A triangle with A < 0 is accepted but never raises any `out_valid_o` bit.
- R3: A triangle with A = 0 is accepted and discarded in the same way as in R2.
- R4: The pixel of a coordinate is the coordinate shifted right by 4. `box_xmin_o` is the smallest vertex pixel x with bit 0 cleared, and `box_xmax_o` is the largest vertex pixel x with bit 0 set. The y bounds are formed the same way.
- R5: Tile (tx, ty) covers pixels 16*tx..16*tx+15 by 16*ty..16*ty+15 and is owned by rasterizer 2*(ty mod 2)+(tx mod 2). For a triangle with A > 0, `out_valid_o[r]` is raised for exactly those rasterizers r that own at least one tile overlapping the box of R4.
- R6: While any `out_valid_o` bit is high, `out_x0_o`..`out_y2_o` carry the vertices of the held triangle unchanged.
- R7: Once raised, `out_valid_o[r]` stays high, with stable data, until `out_ready_i[r]` is seen high. In the cycle after that handshake it is low, unless a new triangle was loaded.
- R8: `tri_ready_o` is high exactly when every raised `out_valid_o` bit also sees its `out_ready_i` high in the same cycle. A new triangle can therefore be accepted in the cycle in which the previous one is released.
- R9: Each rasterizer receives its triangles in input order, and none is lost or duplicated.
- R10: A triangle accepted at a clock edge appears on the outputs right after that edge, that is, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tri_valid_i | input | 1 | Input triangle valid |
| tri_ready_o | output | 1 | Input triangle accepted when high with valid |
| x0_i | input | 14 | Vertex 0 x, 10.4 fixed point |
| y0_i | input | 14 | Vertex 0 y |
| x1_i | input | 14 | Vertex 1 x |
| y1_i | input | 14 | Vertex 1 y |
| x2_i | input | 14 | Vertex 2 x |
| y2_i | input | 14 | Vertex 2 y |
| out_valid_o | output | 4 | Per-rasterizer triangle valid |
| out_ready_i | input | 4 | Per-rasterizer ready |
| out_x0_o | output | 14 | Held vertex 0 x |
| out_y0_o | output | 14 | Held vertex 0 y |
| out_x1_o | output | 14 | Held vertex 1 x |
| out_y1_o | output | 14 | Held vertex 1 y |
| out_x2_o | output | 14 | Held vertex 2 x |
| out_y2_o | output | 14 | Held vertex 2 y |
| box_xmin_o | output | 10 | Quad-aligned box left pixel |
| box_ymin_o | output | 10 | Quad-aligned box top pixel |
| box_xmax_o | output | 10 | Quad-aligned box right pixel |
| box_ymax_o | output | 10 | Quad-aligned box bottom pixel |

## Verification
Two events can land in the same cycle: the last pending rasterizer takes the held triangle, and a new triangle is accepted and loaded into the slot it frees. The bench provokes this with back-to-back triangles while every rasterizer is ready. It also provokes it under random per-rasterizer ready patterns, where the final handshake of a broadcast often comes late. A behavioural model of the slot, built from the requirements, predicts `tri_ready_o`, the valid mask, the vertices and the box on every clock. Directed triangles with hand-computed masks and boxes pin down the cull, quad-alignment and tile-ownership rules.

// File: rtl/tri_dist_pkg.sv
package tri_dist_pkg;
  localparam int PIX_W    = 10;
  localparam int FRAC_W   = 4;
  localparam int CRD_W    = PIX_W + FRAC_W;
  localparam int TILE_LOG = 4;
  localparam int TILE_W   = PIX_W - TILE_LOG;
  localparam int GRID_LOG = 1;
  localparam int GRID     = 1 << GRID_LOG;
  localparam int NUM_RAST = GRID * GRID;
  localparam int AREA_W   = 2 * CRD_W + 5;

  typedef logic [CRD_W-1:0] crd_t;
  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    crd_t x0, y0, x1, y1, x2, y2;
  } tri_t;

  typedef struct packed {
    pix_t xmin, ymin, xmax, ymax;
  } box_t;
endpackage

// File: rtl/tri_cull.sv
module tri_cull import tri_dist_pkg::*; (
  input  tri_t tri_i,
  output logic front_o
);
  logic signed [AREA_W-1:0] ex0, ey0, ex1, ey1, ex2, ey2;
  logic signed [AREA_W-1:0] dx1, dy1, dx2, dy2, area;

  always_comb begin
    ex0 = $signed({{(AREA_W-CRD_W){1'b0}}, tri_i.x0});
    ey0 = $signed({{(AREA_W-CRD_W){1'b0}}, tri_i.y0});
    ex1 = $signed({{(AREA_W-CRD_W){1'b0}}, tri_i.x1});
    ey1 = $signed({{(AREA_W-CRD_W){1'b0}}, tri_i.y1});
    ex2 = $signed({{(AREA_W-CRD_W){1'b0}}, tri_i.x2});
    ey2 = $signed({{(AREA_W-CRD_W){1'b0}}, tri_i.y2});
    dx1 = ex1 - ex0;
    dy1 = ey1 - ey0;
    dx2 = ex2 - ex0;
    dy2 = ey2 - ey0;
    area = dx1 * dy2 - dx2 * dy1;
    // zero area is degenerate and dropped with back faces
    front_o = (area > 0);
  end
endmodule

// File: rtl/tri_bbox.sv
module tri_bbox import tri_dist_pkg::*; (
  input  tri_t tri_i,
  output box_t box_o
);
  function automatic pix_t min3(pix_t a, pix_t b, pix_t c);
    pix_t m;
    m = (a < b) ? a : b;
    return (c < m) ? c : m;
  endfunction

  function automatic pix_t max3(pix_t a, pix_t b, pix_t c);
    pix_t m;
    m = (a > b) ? a : b;
    return (c > m) ? c : m;
  endfunction

  pix_t px0, py0, px1, py1, px2, py2, lo_x, lo_y, hi_x, hi_y;

  always_comb begin
    px0 = tri_i.x0[CRD_W-1:FRAC_W];
    py0 = tri_i.y0[CRD_W-1:FRAC_W];
    px1 = tri_i.x1[CRD_W-1:FRAC_W];
    py1 = tri_i.y1[CRD_W-1:FRAC_W];
    px2 = tri_i.x2[CRD_W-1:FRAC_W];
    py2 = tri_i.y2[CRD_W-1:FRAC_W];
    lo_x = min3(px0, px1, px2);
    lo_y = min3(py0, py1, py2);
    hi_x = max3(px0, px1, px2);
    hi_y = max3(py0, py1, py2);
    // widen to whole 2x2 quads
    box_o.xmin = {lo_x[PIX_W-1:1], 1'b0};
    box_o.ymin = {lo_y[PIX_W-1:1], 1'b0};
    box_o.xmax = {hi_x[PIX_W-1:1], 1'b1};
    box_o.ymax = {hi_y[PIX_W-1:1], 1'b1};
  end
endmodule

// File: rtl/tile_mask.sv
module tile_mask import tri_dist_pkg::*; (
  input  box_t                box_i,
  output logic [NUM_RAST-1:0] mask_o
);
  logic [TILE_W-1:0] tx_lo, tx_hi, ty_lo, ty_hi, span_x, span_y;
  logic [GRID-1:0]   col_hit, row_hit;

  always_comb begin
    tx_lo  = box_i.xmin[PIX_W-1:TILE_LOG];
    tx_hi  = box_i.xmax[PIX_W-1:TILE_LOG];
    ty_lo  = box_i.ymin[PIX_W-1:TILE_LOG];
    ty_hi  = box_i.ymax[PIX_W-1:TILE_LOG];
    span_x = tx_hi - tx_lo;
    span_y = ty_hi - ty_lo;
  end

  // a column residue is hit when its distance from the first tile fits in the span
  for (genvar g = 0; g < GRID; g++) begin : g_axis
    logic [GRID_LOG-1:0] off_x, off_y;
    assign off_x      = GRID_LOG'(g) - tx_lo[GRID_LOG-1:0];
    assign off_y      = GRID_LOG'(g) - ty_lo[GRID_LOG-1:0];
    assign col_hit[g] = span_x >= TILE_W'(off_x);
    assign row_hit[g] = span_y >= TILE_W'(off_y);
  end

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      assign mask_o[r*GRID+c] = row_hit[r] & col_hit[c];
    end
  end
endmodule

// File: rtl/tri_distrib.sv
module tri_distrib import tri_dist_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tri_valid_i,
  output logic                tri_ready_o,
  input  logic [CRD_W-1:0]    x0_i,
  input  logic [CRD_W-1:0]    y0_i,
  input  logic [CRD_W-1:0]    x1_i,
  input  logic [CRD_W-1:0]    y1_i,
  input  logic [CRD_W-1:0]    x2_i,
  input  logic [CRD_W-1:0]    y2_i,
  output logic [NUM_RAST-1:0] out_valid_o,
  input  logic [NUM_RAST-1:0] out_ready_i,
  output logic [CRD_W-1:0]    out_x0_o,
  output logic [CRD_W-1:0]    out_y0_o,
  output logic [CRD_W-1:0]    out_x1_o,
  output logic [CRD_W-1:0]    out_y1_o,
  output logic [CRD_W-1:0]    out_x2_o,
  output logic [CRD_W-1:0]    out_y2_o,
  output logic [PIX_W-1:0]    box_xmin_o,
  output logic [PIX_W-1:0]    box_ymin_o,
  output logic [PIX_W-1:0]    box_xmax_o,
  output logic [PIX_W-1:0]    box_ymax_o
);
  tri_t                in_tri, hold_tri;
  box_t                in_box, hold_box;
  logic                front;
  logic [NUM_RAST-1:0] in_mask, pend, left;
  logic                accept;

  assign in_tri = '{x0: x0_i, y0: y0_i, x1: x1_i, y1: y1_i, x2: x2_i, y2: y2_i};

  tri_cull  u_cull (.tri_i(in_tri), .front_o(front));
  tri_bbox  u_bbox (.tri_i(in_tri), .box_o(in_box));
  tile_mask u_mask (.box_i(in_box), .mask_o(in_mask));

  // slot frees in the cycle its last pending destination accepts
  assign left        = pend & ~out_ready_i;
  assign tri_ready_o = (left == '0);
  assign accept      = tri_valid_i & tri_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend     <= '0;
      hold_tri <= '0;
      hold_box <= '0;
    end else if (accept && front) begin
      pend     <= in_mask;
      hold_tri <= in_tri;
      hold_box <= in_box;
    end else begin
      pend     <= left;
    end
  end

  assign out_valid_o = pend;
  assign out_x0_o    = hold_tri.x0;
  assign out_y0_o    = hold_tri.y0;
  assign out_x1_o    = hold_tri.x1;
  assign out_y1_o    = hold_tri.y1;
  assign out_x2_o    = hold_tri.x2;
  assign out_y2_o    = hold_tri.y2;
  assign box_xmin_o  = hold_box.xmin;
  assign box_ymin_o  = hold_box.ymin;
  assign box_xmax_o  = hold_box.xmax;
  assign box_ymax_o  = hold_box.ymax;

  AST_CULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !front |=> out_valid_o == '0); // R2

  AST_LOAD_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && front |=> out_valid_o != '0); // R5

  AST_BOX_QUAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0) |-> (!box_xmin_o[0] && box_xmax_o[0] && !box_ymin_o[0]
                             && box_ymax_o[0] && box_xmin_o <= box_xmax_o
                             && box_ymin_o <= box_ymax_o)); // R4

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_o & ~out_ready_i) != '0) |=>
      ((out_valid_o & $past(out_valid_o & ~out_ready_i)) == $past(out_valid_o & ~out_ready_i))
      && $stable(out_x0_o) && $stable(out_y2_o) && $stable(box_xmax_o)); // R7

  AST_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_o & out_ready_i) != '0) && !(tri_valid_i && tri_ready_o) |=>
      ((out_valid_o & $past(out_valid_o & out_ready_i)) == '0)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_valid_i && !tri_ready_o |=> out_valid_o != '0); // R8
endmodule

// File: tb/tb_tri_distrib.sv
`timescale 1ns/1ps
module tb_tri_distrib;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tri_valid_i = 1'b0;
  logic        tri_ready_o;
  logic [13:0] x0_i = '0, y0_i = '0, x1_i = '0, y1_i = '0, x2_i = '0, y2_i = '0;
  logic [3:0]  out_valid_o;
  logic [3:0]  out_ready_i = '0;
  logic [13:0] out_x0_o, out_y0_o, out_x1_o, out_y1_o, out_x2_o, out_y2_o;
  logic [9:0]  box_xmin_o, box_ymin_o, box_xmax_o, box_ymax_o;

  always #5 clk_i = ~clk_i;

  tri_distrib dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tri_valid_i(tri_valid_i), .tri_ready_o(tri_ready_o),
    .x0_i(x0_i), .y0_i(y0_i), .x1_i(x1_i), .y1_i(y1_i), .x2_i(x2_i), .y2_i(y2_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_x0_o(out_x0_o), .out_y0_o(out_y0_o), .out_x1_o(out_x1_o),
    .out_y1_o(out_y1_o), .out_x2_o(out_x2_o), .out_y2_o(out_y2_o),
    .box_xmin_o(box_xmin_o), .box_ymin_o(box_ymin_o),
    .box_xmax_o(box_xmax_o), .box_ymax_o(box_ymax_o)
  );

  typedef struct { int v[6]; } ttri_t;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  ttri_t feed_q[$];
  ttri_t cur;
  bit    cur_valid = 0;
  int    m_pend = 0;
  int    m_v[6];
  int    m_b[4];
  int    exp_cnt[4];
  int    got_cnt[4];
  int    ready_mode = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // requirement-level reference: cull, quad box, tile owners
  function automatic void ref_tri(input int v[6], output bit front, output int b[4], output int mask);
    int area, lx, hx, ly, hy;
    area = (v[2]-v[0])*(v[5]-v[1]) - (v[4]-v[0])*(v[3]-v[1]);
    front = area > 0;
    lx = v[0] >> 4; hx = lx;
    ly = v[1] >> 4; hy = ly;
    for (int i = 1; i < 3; i++) begin
      if ((v[2*i] >> 4) < lx) lx = v[2*i] >> 4;
      if ((v[2*i] >> 4) > hx) hx = v[2*i] >> 4;
      if ((v[2*i+1] >> 4) < ly) ly = v[2*i+1] >> 4;
      if ((v[2*i+1] >> 4) > hy) hy = v[2*i+1] >> 4;
    end
    b[0] = lx & ~1; b[1] = ly & ~1; b[2] = hx | 1; b[3] = hy | 1;
    mask = 0;
    for (int ty = b[1] / 16; ty <= b[3] / 16; ty++)
      for (int tx = b[0] / 16; tx <= b[2] / 16; tx++)
        mask |= 1 << (2*(ty % 2) + (tx % 2));
  endfunction

  task automatic drive_tri(input int v[6]);
    x0_i = 14'(v[0]); y0_i = 14'(v[1]); x1_i = 14'(v[2]);
    y1_i = 14'(v[3]); x2_i = 14'(v[4]); y2_i = 14'(v[5]);
  endtask

  task automatic chk_data(input string req);
    chk(out_x0_o == 14'(m_v[0]) && out_y0_o == 14'(m_v[1]) && out_x1_o == 14'(m_v[2]) &&
        out_y1_o == 14'(m_v[3]) && out_x2_o == 14'(m_v[4]) && out_y2_o == 14'(m_v[5]),
        req, "vertices", int'(out_x0_o), m_v[0]);
    chk(box_xmin_o == 10'(m_b[0]) && box_ymin_o == 10'(m_b[1]) &&
        box_xmax_o == 10'(m_b[2]) && box_ymax_o == 10'(m_b[3]),
        "R4", "box", int'(box_xmax_o), m_b[2]);
  endtask

  // one cycle: starts just after a falling edge
  task automatic step();
    int  nxt, b[4], mask;
    bit  front, exp_rdy;
    case (ready_mode)
      0: out_ready_i = 4'hF;
      1: out_ready_i = 4'($urandom_range(0, 15));
      default: out_ready_i = 4'h0;
    endcase
    if (!cur_valid && feed_q.size() > 0) begin
      cur = feed_q.pop_front();
      cur_valid = 1;
    end
    tri_valid_i = cur_valid;
    if (cur_valid) drive_tri(cur.v);
    #1;
    exp_rdy = (m_pend & ~int'(out_ready_i)) == 0;
    chk(tri_ready_o == exp_rdy, "R8", "tri_ready", int'(tri_ready_o), int'(exp_rdy));
    chk(int'(out_valid_o) == m_pend, "R5", "out_valid", int'(out_valid_o), m_pend);
    if (m_pend != 0) chk_data("R9");
    for (int r = 0; r < 4; r++)
      if (m_pend[r] && out_ready_i[r]) got_cnt[r]++;
    nxt = m_pend & ~int'(out_ready_i);
    if (cur_valid && exp_rdy) begin
      ref_tri(cur.v, front, b, mask);
      if (front) begin
        nxt = mask;
        m_v = cur.v;
        m_b = b;
        for (int r = 0; r < 4; r++) if (mask[r]) exp_cnt[r]++;
      end
      cur_valid = 0;
    end
    m_pend = nxt;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic directed(input int v[6], input int emask, input int eb[4], input string req);
    tri_valid_i = 1; out_ready_i = 4'hF; drive_tri(v);
    #1;
    chk(tri_ready_o == 1'b1, "R8", "ready idle", int'(tri_ready_o), 1);
    chk(out_valid_o == 4'h0, "R10", "no output before edge", int'(out_valid_o), 0);
    @(posedge clk_i); @(negedge clk_i);
    tri_valid_i = 0;
    #1;
    chk(int'(out_valid_o) == emask, req, "mask", int'(out_valid_o), emask);
    if (emask != 0) begin
      m_v = v; m_b = eb;
      chk_data("R6");
    end
    @(posedge clk_i); @(negedge clk_i);
    #1;
    chk(out_valid_o == 4'h0, "R7", "drop after handshake", int'(out_valid_o), 0);
  endtask

  function automatic ttri_t mk(int a, int b, int c, int d, int e, int f);
    ttri_t t;
    t.v = '{a, b, c, d, e, f};
    return t;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    ttri_t t;
    for (int r = 0; r < 4; r++) begin exp_cnt[r] = 0; got_cnt[r] = 0; end
    repeat (3) @(negedge clk_i);
    #1;
    chk(tri_ready_o == 1'b1, "R1", "ready in reset", int'(tri_ready_o), 1);
    chk(out_valid_o == 4'h0, "R1", "valid in reset", int'(out_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    #1;
    chk(out_valid_o == 4'h0 && tri_ready_o, "R1", "after reset", int'(out_valid_o), 0);
    @(negedge clk_i);

    // pixel 3.9 .. 12 -> box x 2..13, y 4..15, tile 0
    directed('{63, 80, 192, 80, 48, 224}, 4'b0001, '{2, 4, 13, 15}, "R4");
    directed('{160, 32, 320, 32, 160, 192}, 4'b0011, '{10, 2, 21, 13}, "R5");
    directed('{272, 272, 432, 272, 272, 432}, 4'b1000, '{16, 16, 27, 27}, "R5");
    directed('{320, 160, 400, 160, 320, 320}, 4'b1010, '{20, 10, 25, 21}, "R5");
    directed('{0, 0, 1600, 0, 0, 1600}, 4'b1111, '{0, 0, 101, 101}, "R5");
    directed('{0, 0, 0, 128, 128, 0}, 4'b0000, '{0, 0, 0, 0}, "R2");
    directed('{0, 0, 64, 64, 128, 128}, 4'b0000, '{0, 0, 0, 0}, "R3");

    // back-to-back with all ready: release and accept coincide
    ready_mode = 0;
    for (int i = 0; i < 40; i++) begin
      int bx = $urandom_range(0, 14000), by = $urandom_range(0, 14000);
      feed_q.push_back(mk(bx, by, bx + $urandom_range(0, 900), by,
                          bx, by + $urandom_range(0, 900)));
    end
    while (feed_q.size() > 0 || cur_valid || m_pend != 0) step();

    // random ready, mixed sizes and windings
    ready_mode = 1;
    for (int i = 0; i < 400; i++) begin
      if (i % 3 == 0)
        t = mk($urandom_range(0, 16383), $urandom_range(0, 16383), $urandom_range(0, 16383),
               $urandom_range(0, 16383), $urandom_range(0, 16383), $urandom_range(0, 16383));
      else begin
        int bx = $urandom_range(0, 15000), by = $urandom_range(0, 15000);
        t = mk(bx + $urandom_range(0, 600), by + $urandom_range(0, 600),
               bx + $urandom_range(0, 600), by + $urandom_range(0, 600),
               bx + $urandom_range(0, 600), by + $urandom_range(0, 600));
      end
      feed_q.push_back(t);
    end
    for (int i = 0; i < 20000 && (feed_q.size() > 0 || cur_valid || m_pend != 0); i++) begin
      if (i % 50 == 20) ready_mode = 2;
      if (i % 50 == 26) ready_mode = 1;
      step();
    end
    ready_mode = 0;
    while (feed_q.size() > 0 || cur_valid || m_pend != 0) step();
    step();

    for (int r = 0; r < 4; r++)
      chk(got_cnt[r] == exp_cnt[r], "R9", "delivered count", got_cnt[r], exp_cnt[r]);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule